// File: doc/BRIEF.md
# Cascaded LFSR Milestone Timer

This block measures a fixed series of intervals with a chain of small counters, each built from a maximal-length linear feedback shift register rather than a binary incrementer. Every stage holds one interval length that is fixed when the design is elaborated. The stage loads a seed, advances one pseudo-random step per clock once it is started, and ends its interval when the whole register equals a terminal pattern. That pattern is computed at elaboration by stepping the same feedback function from the seed.

A stage that reaches its terminal pattern raises its done output for one cycle, reloads its seed and goes idle. In that same cycle it starts the next stage. The done outputs therefore mark cumulative milestones after one external start pulse. For example, lengths 8, 8 and 48 give pulses at 8, 16 and 64 cycles. A single register cannot encode more than one terminal count, so each extra milestone needs one more stage.

Each stage's register width is the smallest width from 3 to 16 whose period 2^n−1 covers its length. The feedback comes from a built-in table of maximal-length taps. The XOR or XNOR feedback form is chosen by a parameter.

Top module: `lfsr_chain_timer`

## Requirements
- R1: While reset is high, and in every cycle after reset until a start is accepted, all done outputs are low. A reset during a run abandons that run, so no done pulse follows it.
- R2: If the start input is high in cycle c while the chain is idle, stage 0 raises its done output in cycle c+L0, where L0 is its configured length.
- R3: Stage k>0 starts in the cycle in which stage k−1 pulses done. Its done pulse falls in cycle c plus the sum of the lengths of stages 0..k.
- R4: In each run, each done output is high for exactly one cycle, and no two done outputs are high in the same cycle.
- R5: A start that arrives while any stage is active is ignored. This includes the cycle in which the last stage pulses done. No run is extended, restarted or added as a result.
- R6: A length of 1 gives a done pulse in the cycle after the stage starts. A length equal to the full period 2^n−1 of the selected width (for example 255 or 511) counts exactly.
- R7: With the XNOR feedback form and an all-zero seed, the timing is the same as with XOR feedback. A stage register never holds the pattern that the feedback form would lock on: all zeros for XOR, all ones for XNOR.
- R8: After a run, every stage is back at its seed. Back-to-back runs repeat the same milestone timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request for the chain, honoured only while every stage is idle |
| done_o | output | NUM_STAGES | One-cycle milestone pulse per stage, bit k for stage k |

## Verification
The bench builds three chains. The first uses XOR feedback with lengths 8, 8 and 48, which covers the plain cumulative milestones and the busy-start cases. The second uses XNOR feedback with an all-zero seed and lengths 1, 3 and 100; it reaches the single-cycle stage, a 3-bit register and the XNOR lock pattern. The third uses lengths 255, 2 and 511, a non-trivial seed, and two stages whose length equals the whole period of an 8-bit and a 9-bit register. In every run, each done pulse is compared with a plain cycle count taken from the accepted start.

// File: rtl/lfsr_chain_pkg.sv
package lfsr_chain_pkg;

   localparam int unsigned MIN_W   = 3;
   localparam int unsigned MAX_W   = 16;
   localparam int unsigned MAX_LEN = (32'd1 << MAX_W) - 32'd1;
   localparam int unsigned CNT_W   = MAX_W + 1;

   typedef logic [MAX_W-1:0] lfsr_word_t;

   // Maximal-length tap set per width, bit i set means register bit i feeds back
   function automatic lfsr_word_t tap_mask(input int unsigned w);
      lfsr_word_t m;
      case (w)
         3:       m = 16'h0006;
         4:       m = 16'h000C;
         5:       m = 16'h0014;
         6:       m = 16'h0030;
         7:       m = 16'h0060;
         8:       m = 16'h00B8;
         9:       m = 16'h0110;
         10:      m = 16'h0240;
         11:      m = 16'h0500;
         12:      m = 16'h0829;
         13:      m = 16'h100D;
         14:      m = 16'h2015;
         15:      m = 16'h6000;
         16:      m = 16'hD008;
         default: m = 16'h0006;
      endcase
      return m;
   endfunction

   // Low w bits set
   function automatic lfsr_word_t width_mask(input int unsigned w);
      lfsr_word_t m;
      m = '0;
      for (int unsigned i = 0; i < MAX_W; i++) begin
         if (i < w) m[i] = 1'b1;
      end
      return m;
   endfunction

   // Smallest width whose period covers len
   function automatic int unsigned width_for_len(input int unsigned len);
      int unsigned r;
      bit          found;
      r     = MAX_W;
      found = 1'b0;
      for (int unsigned n = MIN_W; n <= MAX_W; n++) begin
         if (!found && (((32'd1 << n) - 32'd1) >= len)) begin
            r     = n;
            found = 1'b1;
         end
      end
      return r;
   endfunction

   // One shift of the register, new bit enters at position 0
   function automatic lfsr_word_t lfsr_step(input lfsr_word_t s,
                                            input int unsigned w,
                                            input bit xnor_fb);
      logic fb;
      fb = ^(s & tap_mask(w));
      if (xnor_fb) fb = ~fb;
      return ((s << 1) | {{(MAX_W-1){1'b0}}, fb}) & width_mask(w);
   endfunction

   // State reached after len-1 steps from the seed
   function automatic lfsr_word_t terminal_state(input lfsr_word_t seed,
                                                 input int unsigned w,
                                                 input bit xnor_fb,
                                                 input int unsigned len);
      lfsr_word_t s;
      s = seed & width_mask(w);
      for (int unsigned i = 1; i < len; i++) begin
         s = lfsr_step(s, w, xnor_fb);
      end
      return s;
   endfunction

   // Pattern the feedback can never leave
   function automatic lfsr_word_t lock_state(input int unsigned w, input bit xnor_fb);
      return xnor_fb ? width_mask(w) : '0;
   endfunction

endpackage

// File: rtl/lfsr_chain_feedback.sv
module lfsr_chain_feedback #(
   parameter int unsigned W       = 8,
   parameter logic [W-1:0] TAPS   = '1,
   parameter bit          XNOR_FB = 1'b0
) (
   input  logic [W-1:0] state_i,
   output logic [W-1:0] next_o
);

   logic fb;

   if (W < 3) begin : g_bad_w
      $error("lfsr_chain_feedback: W must be at least 3");
   end

   if (XNOR_FB) begin : g_xnor
      assign fb = ~^(state_i & TAPS);
   end else begin : g_xor
      assign fb = ^(state_i & TAPS);
   end

   assign next_o = {state_i[W-2:0], fb};

endmodule

// File: rtl/lfsr_chain_stage.sv
module lfsr_chain_stage
   import lfsr_chain_pkg::*;
#(
   parameter int unsigned LEN     = 8,
   parameter logic [15:0] SEED    = 16'h0001,
   parameter bit          XNOR_FB = 1'b0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic start_i,
   output logic done_o,
   output logic active_o
);

   localparam int unsigned W         = width_for_len(LEN);
   localparam lfsr_word_t  SEED_FULL = SEED & width_mask(W);
   localparam lfsr_word_t  TERM_FULL = terminal_state(SEED, W, XNOR_FB, LEN);
   localparam lfsr_word_t  LOCK_FULL = lock_state(W, XNOR_FB);
   localparam lfsr_word_t  TAP_FULL  = tap_mask(W);
   localparam logic [W-1:0] SEED_W   = SEED_FULL[W-1:0];
   localparam logic [W-1:0] TERM_W   = TERM_FULL[W-1:0];
   localparam logic [W-1:0] LOCK_W   = LOCK_FULL[W-1:0];
   localparam logic [W-1:0] TAP_W    = TAP_FULL[W-1:0];
   localparam logic [CNT_W-1:0] LEN_C = CNT_W'(LEN);

   if (LEN == 0 || LEN > MAX_LEN) begin : g_bad_len
      $error("lfsr_chain_stage: LEN out of range");
   end
   if (SEED_W == LOCK_W) begin : g_bad_seed
      $error("lfsr_chain_stage: seed equals the lock-up pattern");
   end

   logic [W-1:0] state_q;
   logic [W-1:0] state_next;
   logic         active_q;
   logic         at_term;

   lfsr_chain_feedback #(
      .W       (W),
      .TAPS    (TAP_W),
      .XNOR_FB (XNOR_FB)
   ) u_fb (
      .state_i (state_q),
      .next_o  (state_next)
   );

   assign at_term  = (state_q == TERM_W);
   assign done_o   = active_q & at_term;
   assign active_o = active_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         state_q  <= SEED_W;
         active_q <= 1'b0;
      end else if (active_q) begin
         if (at_term) begin
            state_q  <= SEED_W;
            active_q <= 1'b0;
         end else begin
            state_q  <= state_next;
         end
      end else if (start_i) begin
         active_q <= 1'b1;
      end
   end

   // Cycle count of the current run, used only by the length check
   logic [CNT_W-1:0] run_cnt_q;
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         run_cnt_q <= '0;
      end else if (!active_q && start_i) begin
         run_cnt_q <= CNT_W'(1);
      end else if (active_q && !done_o) begin
         run_cnt_q <= run_cnt_q + CNT_W'(1);
      end else if (done_o) begin
         run_cnt_q <= '0;
      end
   end

   AST_RUN_LENGTH: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> (run_cnt_q == LEN_C));                                    // R2
   AST_NO_EARLY: assert property (@(posedge clk_i) disable iff (rst_i)
      (active_q && run_cnt_q < LEN_C) |-> !done_o);                        // R2
   AST_PULSE_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> !done_o);                                                 // R4
   AST_NO_LOCK: assert property (@(posedge clk_i) disable iff (rst_i)
      state_q != LOCK_W);                                                  // R7
   AST_IDLE_SEED: assert property (@(posedge clk_i) disable iff (rst_i)
      !active_q |-> (state_q == SEED_W));                                  // R8

endmodule

// File: rtl/lfsr_chain_timer.sv
module lfsr_chain_timer
   import lfsr_chain_pkg::*;
#(
   parameter int unsigned NUM_STAGES = 3,
   parameter logic [NUM_STAGES-1:0][31:0] STAGE_LEN = {32'd48, 32'd8, 32'd8},
   parameter logic [15:0] SEED    = 16'h0001,
   parameter bit          XNOR_FB = 1'b0
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic                  start_i,
   output logic [NUM_STAGES-1:0] done_o
);

   if (NUM_STAGES < 1) begin : g_bad_n
      $error("lfsr_chain_timer: NUM_STAGES must be at least 1");
   end

   logic [NUM_STAGES-1:0] active_w;
   logic [NUM_STAGES-1:0] kick_w;
   logic                  busy;

   assign busy = |active_w;

   for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
      if (k == 0) begin : g_head
         assign kick_w[k] = start_i & ~busy;
      end else begin : g_link
         assign kick_w[k] = done_o[k-1];
      end

      lfsr_chain_stage #(
         .LEN     (int'(STAGE_LEN[k])),
         .SEED    (SEED),
         .XNOR_FB (XNOR_FB)
      ) u_stage (
         .clk_i    (clk_i),
         .rst_i    (rst_i),
         .start_i  (kick_w[k]),
         .done_o   (done_o[k]),
         .active_o (active_w[k])
      );
   end

   for (genvar k = 0; k + 1 < NUM_STAGES; k++) begin : g_handoff_chk
      AST_HANDOFF: assert property (@(posedge clk_i) disable iff (rst_i)
         done_o[k] |=> active_w[k+1]);                                     // R3
   end

   AST_ONE_MILESTONE: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(done_o));                                                   // R4
   AST_IGNORE_BUSY: assert property (@(posedge clk_i) disable iff (rst_i)
      (start_i && busy && !active_w[0]) |=> !active_w[0]);                 // R5

endmodule

// File: tb/lfsr_chain_timer_bench.sv
module lfsr_chain_timer_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 6;
   // table: configuration, idle gap before start, expected final milestone
   localparam int VEC_CFG   [NV] = '{0, 1, 2, 0, 1, 0};
   localparam int VEC_GAP   [NV] = '{0, 3, 1, 0, 0, 2};
   localparam int VEC_TOTAL [NV] = '{64, 104, 768, 64, 104, 64};

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start_a = 1'b0, start_b = 1'b0, start_c = 1'b0;
   logic [2:0] done_a, done_b, done_c;
   int         n_total = 0;
   int         n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lfsr_chain_timer #(
      .NUM_STAGES (3), .STAGE_LEN ({32'd48, 32'd8, 32'd8}),
      .SEED (16'h0001), .XNOR_FB (1'b0)
   ) u_lfsr_chain_timer (
      .clk_i (clk), .rst_i (rst), .start_i (start_a), .done_o (done_a));

   lfsr_chain_timer #(
      .NUM_STAGES (3), .STAGE_LEN ({32'd100, 32'd3, 32'd1}),
      .SEED (16'h0000), .XNOR_FB (1'b1)
   ) u_lfsr_chain_timer_b (
      .clk_i (clk), .rst_i (rst), .start_i (start_b), .done_o (done_b));

   lfsr_chain_timer #(
      .NUM_STAGES (3), .STAGE_LEN ({32'd511, 32'd2, 32'd255}),
      .SEED (16'h005A), .XNOR_FB (1'b0)
   ) u_lfsr_chain_timer_c (
      .clk_i (clk), .rst_i (rst), .start_i (start_c), .done_o (done_c));

   function automatic int stage_len(int cfg, int k);
      int a [3] = '{8, 8, 48};
      int b [3] = '{1, 3, 100};
      int c [3] = '{255, 2, 511};
      case (cfg)
         0: return a[k];
         1: return b[k];
         default: return c[k];
      endcase
   endfunction

   function automatic int cum_len(int cfg, int k);
      int s = 0;
      for (int i = 0; i <= k; i++) s += stage_len(cfg, i);
      return s;
   endfunction

   function automatic logic [2:0] done_of(int cfg);
      case (cfg)
         0: return done_a;
         1: return done_b;
         default: return done_c;
      endcase
   endfunction

   task automatic set_start(int cfg, logic v);
      case (cfg)
         0: start_a = v;
         1: start_b = v;
         default: start_c = v;
      endcase
   endtask

   task automatic check(bit ok, string req, int act, int exp);
      n_total++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Start one run and compare each done pulse with a cycle count from the start.
   // x1/x2: cycles (relative to the start cycle) in which an extra start is driven.
   task automatic run_chain(int cfg, int gap, int total, int x1, int x2, int window,
                            string tag);
      int seen [3];
      int highs [3];
      logic [2:0] d;
      for (int k = 0; k < 3; k++) begin seen[k] = -1; highs[k] = 0; end
      repeat (gap) @(negedge clk);
      set_start(cfg, 1'b1);
      for (int j = 1; j <= total + window; j++) begin
         @(negedge clk);
         d = done_of(cfg);
         set_start(cfg, (j == x1 || j == x2) ? 1'b1 : 1'b0);
         for (int k = 0; k < 3; k++) begin
            if (d[k]) begin
               highs[k]++;
               if (seen[k] < 0) seen[k] = j;
            end
         end
      end
      set_start(cfg, 1'b0);
      check(seen[0] == cum_len(cfg, 0), {tag, " R2 stage0 cycle"}, seen[0], cum_len(cfg, 0));
      check(seen[1] == cum_len(cfg, 1), {tag, " R3 stage1 cycle"}, seen[1], cum_len(cfg, 1));
      check(seen[2] == total, {tag, " R3 stage2 cycle"}, seen[2], total);
      for (int k = 0; k < 3; k++)
         check(highs[k] == 1, {tag, " R4 pulse count"}, highs[k], 1);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_total++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

   initial begin
      int quiet;
      // R1: reset state
      repeat (3) @(negedge clk);
      check(done_a == 3'b0 && done_b == 3'b0 && done_c == 3'b0, "R1 in reset",
            int'({done_a, done_b, done_c}), 0);
      rst = 1'b0;
      quiet = 0;
      for (int j = 0; j < 20; j++) begin
         @(negedge clk);
         if (done_a != 0 || done_b != 0 || done_c != 0) quiet++;
      end
      check(quiet == 0, "R1 idle without start", quiet, 0);

      // table walk: R2 R3 R4, R6 (len 1, 255, 511), R7 (XNOR), R8 (repeat runs)
      for (int v = 0; v < NV; v++) begin
         run_chain(VEC_CFG[v], VEC_GAP[v], VEC_TOTAL[v], -1, -1, 4,
                   (v >= 3) ? "R8 repeat" : ((VEC_CFG[v] == 1) ? "R7 R6" :
                   ((VEC_CFG[v] == 2) ? "R6 period" : "base")));
      end

      // R5: starts during stage 1 and during the final done cycle are ignored
      run_chain(0, 1, 64, 12, 64, 60, "R5 busy start");
      // R5 again on the XNOR chain: start while stage 2 runs
      run_chain(1, 0, 104, 50, -1, 10, "R5 busy start b");

      // R1: reset in the middle of a run leaves no pulse behind
      @(negedge clk);
      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      repeat (12) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      check(done_a == 3'b0, "R1 during mid-run reset", int'(done_a), 0);
      rst = 1'b0;
      quiet = 0;
      for (int j = 0; j < 80; j++) begin
         @(negedge clk);
         if (done_a != 0) quiet++;
      end
      check(quiet == 0, "R1 run abandoned by reset", quiet, 0);

      // R8: a clean run after the aborted one
      run_chain(0, 0, 64, -1, -1, 4, "R8 after reset");

      $display("test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
   end

endmodule